// File: doc/BRIEF.md
# Sequential Shift-Subtract Integer Divider

This block divides one unsigned 32-bit integer by another over many clock cycles, one quotient bit per cycle, producing a quotient and a remainder. Its datapath is deliberately small: one divisor register, one subtractor as wide as a word, and a single double-width working register. The quotient has no register of its own. Its bits are shifted into the lower half of the working register as that register moves left. When the run finishes, the lower half holds the quotient and the upper half holds the remainder.

A client presents a dividend and a divisor together with a one-cycle start pulse while the block is idle. The block raises busy and iterates. It then pulses done for one cycle and holds the results until the next accepted start. A zero divisor skips the iterations and raises a divide-by-zero flag instead.

Top module: `shiftsub_divider`

## Requirements
- R1: After reset, busy, done and div_zero are 0, and quotient and remainder are 0.
- R2: A start while idle with a nonzero divisor sets busy at the next clock edge. Busy then stays 1 for exactly 33 cycles.
- R3: For a nonzero divisor, done is 1 for exactly one cycle. It rises on the 33rd clock edge after the edge that accepted start, which is the same edge on which busy falls.
- R4: When done rises for a nonzero divisor, quotient equals floor(dividend / divisor) and remainder equals dividend mod divisor. Both are unsigned, and this holds for every 32-bit divisor including values of 2^31 and above; the remainder is always below the divisor.
- R5: While idle and without a new start, quotient, remainder and div_zero hold the values of the last completed operation.
- R6: A start pulse while busy is ignored. The operation in progress finishes with its original operands and timing.
- R7: A start while idle with divisor 0 raises done and div_zero on the next clock edge. Quotient becomes all ones, remainder becomes the dividend, and busy stays 0.
- R8: div_zero is cleared by the next accepted start with a nonzero divisor, at the edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| dividend | input | 32 | Unsigned dividend, sampled with start |
| divisor | input | 32 | Unsigned divisor, sampled with start |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle completion pulse |
| div_zero | output | 1 | Last operation had a zero divisor |
| quotient | output | 32 | Lower half of the working register |
| remainder | output | 32 | Upper half of the working register |

## Verification
For a nonzero divisor, busy is due one edge after the accepting edge, and done and the results are due 33 edges after it. For a zero divisor, done and the flag are due one edge after it. The bench keeps a behavioural model that counts down those edges from each accepted start. At every falling edge it compares busy, done and the flag with the model. Quotient and remainder are compared whenever the model is idle, which covers both the completion cycle and the hold that follows. Ignored starts are confirmed through the final result of the run they interrupted.

// File: rtl/shiftsub_divider.sv
module shiftsub_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic         div_zero,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  localparam int CW = $clog2(W);

  typedef enum logic [1:0] {S_IDLE, S_ITER, S_FIX} st_t;

  st_t            st;
  logic [2*W-1:0] acc;
  logic           carry;
  logic [W-1:0]   dsr;
  logic [CW-1:0]  cnt;
  logic [W:0]     diff;
  logic           fits;

  assign diff      = {carry, acc[2*W-1:W]} - {1'b0, dsr};
  assign fits      = ~diff[W];
  assign busy      = (st != S_IDLE);
  assign quotient  = acc[W-1:0];
  assign remainder = acc[2*W-1:W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      acc      <= '0;
      carry    <= 1'b0;
      dsr      <= '0;
      cnt      <= '0;
      done     <= 1'b0;
      div_zero <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          carry    <= 1'b0;
          div_zero <= (divisor == '0);
          if (divisor == '0) begin
            acc  <= {dividend, {W{1'b1}}};
            done <= 1'b1;
          end else begin
            acc <= {{(W-1){1'b0}}, dividend, 1'b0};
            dsr <= divisor;
            cnt <= '0;
            st  <= S_ITER;
          end
        end
        S_ITER: begin
          if (fits) {carry, acc} <= {diff[W-1:0], acc[W-1:0], 1'b1};
          else      {carry, acc} <= {acc, 1'b0};
          cnt <= cnt + 1'b1;
          if (cnt == CW'(W-1)) st <= S_FIX;
        end
        S_FIX: begin
          acc[2*W-1:W] <= {carry, acc[2*W-1:W+1]};
          carry        <= 1'b0;
          done         <= 1'b1;
          st           <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module shiftsub_divider_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] divisor,
  input logic         busy,
  input logic         done,
  input logic         div_zero,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder
);
  logic [W-1:0] seen_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_d <= '0;
    else if (start && !busy) seen_d <= divisor;
  end

  a_r2_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && divisor != '0) |=> busy);

  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r3_busy_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r4_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_zero) |-> (remainder < seen_d));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(div_zero)));

  a_r7_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && divisor == '0) |=> (done && div_zero && !busy && quotient == '1));

  a_r8_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && divisor != '0) |=> !div_zero);
endmodule

bind shiftsub_divider shiftsub_divider_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .divisor(divisor),
  .busy(busy), .done(done), .div_zero(div_zero),
  .quotient(quotient), .remainder(remainder)
);

// File: tb/shiftsub_divider_tb.sv
module shiftsub_divider_tb;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] dividend = '0, divisor = '0;
  logic busy, done, div_zero;
  logic [W-1:0] quotient, remainder;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  shiftsub_divider #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .div_zero(div_zero),
    .quotient(quotient), .remainder(remainder)
  );

  // behavioural reference
  bit m_busy = 0, m_done = 0, m_z = 0;
  logic [W-1:0] m_q = '0, m_r = '0, m_a = '0, m_b = '0;
  int m_cnt = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      m_done = 0;
      if (!m_busy && start) begin
        if (divisor == '0) begin
          m_done = 1; m_z = 1; m_q = '1; m_r = dividend;
        end else begin
          m_busy = 1; m_z = 0; m_cnt = 33; m_a = dividend; m_b = divisor;
        end
      end else if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1; m_q = m_a / m_b; m_r = m_a % m_b;
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2", "busy", W'(busy), W'(m_busy));
      chk(m_z ? "R7" : "R3", "done", W'(done), W'(m_done));
      chk(m_z ? "R7" : "R8", "div_zero", W'(div_zero), W'(m_z));
      if (!m_busy) begin
        chk(m_done ? "R4" : "R5", "quotient", quotient, m_q);
        chk(m_done ? "R4" : "R5", "remainder", remainder, m_r);
      end
    end
  end

  task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    start = 1'b1; dividend = a; divisor = b;
    @(negedge clk);
    start = 1'b0; dividend = $urandom; divisor = $urandom;
    while (m_busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] seed;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy", W'(busy), '0);
    chk("R1", "done", W'(done), '0);
    chk("R1", "div_zero", W'(div_zero), '0);
    chk("R1", "quotient", quotient, '0);
    chk("R1", "remainder", remainder, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_div(32'd100, 32'd7);
    run_div(32'hFFFF_FFFF, 32'd1);
    run_div(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_div(32'd5, 32'd9);
    run_div(32'hFFFF_FFFF, 32'h8000_0001);   // R4 large divisor
    run_div(32'hC000_0000, 32'h8000_0000);
    run_div(32'd0, 32'd5);
    run_div(32'd1234, 32'd0);                // R7
    chk("R7", "remainder after zero divisor", remainder, 32'd1234);
    run_div(32'd77, 32'd3);                  // R8 clears flag
    chk("R8", "div_zero cleared", W'(div_zero), '0);

    // R6: start while busy is ignored
    @(negedge clk);
    start = 1'b1; dividend = 32'd1000; divisor = 32'd3;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    start = 1'b1; dividend = 32'd9; divisor = 32'd0;
    @(negedge clk);
    start = 1'b0;
    while (m_busy) @(negedge clk);
    chk("R6", "quotient of interrupted run", quotient, 32'd333);
    chk("R6", "remainder of interrupted run", remainder, 32'd1);
    chk("R6", "div_zero of interrupted run", W'(div_zero), '0);
    repeat (2) @(negedge clk);

    seed = 32'h1234_5678;
    for (int i = 0; i < 20; i++) begin
      logic [W-1:0] a, b;
      seed = seed * 32'd1664525 + 32'd1013904223;
      a = seed;
      seed = seed * 32'd1664525 + 32'd1013904223;
      b = seed >> (seed[4:0]);
      run_div(a, b);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule